// File: doc/BRIEF.md
# I2C Display-Bridge Control Target

This block is an I2C target that stands in for the control-register front end of a video transmitter bridge. It runs on a fast system clock and oversamples SCL and SDA. It finds START and STOP conditions and answers to one 7-bit bus address. During reads it drives SDA low through an open-drain enable. There is one byte-wide register pointer. In a write transfer the first data byte after the address loads the pointer. Each later byte is written to the register that the pointer selects, and a read transfer returns that register. The pointer steps forward after each data byte, whether the byte is read or written.

Only a few locations behave. An identity location always returns a fixed code. An interrupt-status location always reports a plugged-in sink with no pending events. A system-control location carries a bus request/grant handshake for the display data channel. When software requests the side channel and grants it in the same write, the block raises a pin that tells the surrounding logic to route the bus into pass-through. Every other location reads as zero and drops writes.

Top module: `vid_bridge_i2c_target`

## Requirements
- R1: The block ACKs an address byte whose upper seven bits equal the TARGET_ADDR parameter (default 7'h39, so 0x72 to write and 0x73 to read). It NACKs any other address and then ignores the bus, ACKing nothing and changing no state, until the next START.
- R2: In a write transfer the first byte after the address loads the register pointer and is not written into any register.
- R3: The pointer increases by one after each data byte read or written, except the pointer-load byte, and wraps from 0xFF to 0x00.
- R4: Reading location 0x1B returns 0xB0.
- R5: Reading location 0x3D returns 0x04 (sink present, no event bits).
- R6: Writing location 0x1A with bit 2 set sets the request flag. If bit 1 is also set in that byte, ddcMode goes high.
- R7: Writing location 0x1A with bit 2 clear clears the request flag and drives ddcMode low.
- R8: Reading location 0x1A returns 0x06 while the request flag is set and 0x00 while it is clear.
- R9: Reads of any other location return 0x00. Writes to any other location are ACKed and have no effect.
- R10: After reset the pointer is 0x00, no pointer load is pending, the request flag is clear, ddcMode is low and sdaOe is low.
- R11: Read data leaves MSB first on sdaOe (high means SDA pulled low). After a master NACK the block stops driving and releases SDA.
- R12: A repeated START in the read direction keeps the pointer, so setting the pointer and then reading returns the selected location.
- R13: A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | High pulls SDA low (open drain) |
| ddcMode | output | 1 | High while the side-channel pass-through is granted |

## Verification
A wrong pointer shows up on the very next byte read through a repeated START, because the returned value comes from the wrong location. The pointer wrap only becomes visible after a read burst long enough to reach the identity location again. A bad request or grant flag shows on ddcMode at once, and on the next read of location 0x1A. An error in the bit counter or the bus state corrupts the first ACK slot that follows it, so the master sees a missing or extra ACK within one byte time.

// File: rtl/vbt_pkg.sv
package vbt_pkg;

  localparam int BYTE_W = 8;

  // Register locations and fixed read values
  localparam logic [BYTE_W-1:0] REG_SYSCTL    = 8'h1A;
  localparam logic [BYTE_W-1:0] REG_IDENT     = 8'h1B;
  localparam logic [BYTE_W-1:0] REG_IRQSTAT   = 8'h3D;
  localparam logic [BYTE_W-1:0] IDENT_VALUE   = 8'hB0;
  localparam logic [BYTE_W-1:0] IRQSTAT_VALUE = 8'h04;
  localparam logic [BYTE_W-1:0] GRANT_VALUE   = 8'h06;
  localparam int BIT_REQ   = 2;
  localparam int BIT_GRANT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRITE,
    ST_WR_ACK,
    ST_READ,
    ST_RD_ACK
  } busState_t;

  // Strobes from bus control to the register datapath
  typedef struct packed {
    logic shiftIn;      // sample one received bit
    logic inBit;        // the bit value to sample
    logic armPtrLoad;   // write-direction address matched
    logic commitWrite;  // a full data byte was received
    logic loadTx;       // fetch the selected location into the transmit shifter
    logic shiftTx;      // advance the transmit shifter by one bit
  } ctlStrobe_t;

endpackage

// File: rtl/vbt_sync.sv
module vbt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  // The bus idles high, so the chain resets to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/vbt_bus_ctrl.sv
module vbt_bus_ctrl
  import vbt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output ctlStrobe_t        strb,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

  busState_t        state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic             rwRead, rwReadNext;
  logic             masterAck, masterAckNext;
  logic             sclQ, sdaQ;
  logic             sclRise, sclFall, startDet, stopDet;

  // One-cycle history for edge and condition detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  always_comb begin
    stateNext     = state;
    bitCntNext    = bitCnt;
    rwReadNext    = rwRead;
    masterAckNext = masterAck;
    strb          = '0;
    strb.inBit    = sdaS;

    if (startDet) begin
      stateNext  = ST_ADDR;
      bitCntNext = '0;
    end else if (stopDet) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_WRITE: begin
          if (sclRise && bitCnt < FULL_CNT) begin
            strb.shiftIn = 1'b1;
            bitCntNext   = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            if (state == ST_ADDR) begin
              if (rxByte[BYTE_W-1:1] == TARGET_ADDR) begin
                stateNext       = ST_ADDR_ACK;
                rwReadNext      = rxByte[0];
                strb.armPtrLoad = ~rxByte[0];
              end else begin
                stateNext = ST_IDLE;
              end
            end else begin
              stateNext        = ST_WR_ACK;
              strb.commitWrite = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCntNext = '0;
            if (rwRead) begin
              stateNext   = ST_READ;
              strb.loadTx = 1'b1;
            end else begin
              stateNext = ST_WRITE;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            stateNext  = ST_WRITE;
            bitCntNext = '0;
          end
        end
        ST_READ: begin
          if (sclFall) begin
            if (bitCnt == LAST_CNT) begin
              stateNext = ST_RD_ACK;
            end else begin
              strb.shiftTx = 1'b1;
              bitCntNext   = bitCnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            masterAckNext = ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              stateNext   = ST_READ;
              bitCntNext  = '0;
              strb.loadTx = 1'b1;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rwRead    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNext;
      bitCnt    <= bitCntNext;
      rwRead    <= rwReadNext;
      masterAck <= masterAckNext;
    end
  end

  // Open-drain drive: ACK slots and zero bits of read data
  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                 ((state == ST_READ) && !txMsb);

endmodule

// File: rtl/vbt_regfile.sv
module vbt_regfile
  import vbt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [BYTE_W-1:0] ptrVal,
  output logic              reqFlag,
  output logic              ddcMode
);

  logic [BYTE_W-1:0] rxShift, txShift, ptr, readValue;
  logic              ptrLoadPending, grantFlag;

  always_comb begin
    case (ptr)
      REG_SYSCTL:  readValue = reqFlag ? GRANT_VALUE : '0;
      REG_IDENT:   readValue = IDENT_VALUE;
      REG_IRQSTAT: readValue = IRQSTAT_VALUE;
      default:     readValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift        <= '0;
      txShift        <= '0;
      ptr            <= '0;
      ptrLoadPending <= 1'b0;
      reqFlag        <= 1'b0;
      grantFlag      <= 1'b0;
    end else begin
      if (strb.shiftIn) begin
        rxShift <= {rxShift[BYTE_W-2:0], strb.inBit};
      end
      if (strb.armPtrLoad) begin
        ptrLoadPending <= 1'b1;
      end
      if (strb.commitWrite) begin
        if (ptrLoadPending) begin
          ptr            <= rxShift;
          ptrLoadPending <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
          if (ptr == REG_SYSCTL) begin
            if (rxShift[BIT_REQ]) begin
              reqFlag <= 1'b1;
              if (rxShift[BIT_GRANT]) begin
                grantFlag <= 1'b1;
              end
            end else begin
              reqFlag   <= 1'b0;
              grantFlag <= 1'b0;
            end
          end
        end
      end
      if (strb.loadTx) begin
        txShift <= readValue;
        ptr     <= ptr + 1'b1;
      end else if (strb.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign rxByte  = rxShift;
  assign txMsb   = txShift[BYTE_W-1];
  assign ptrVal  = ptr;
  assign ddcMode = grantFlag;

endmodule

// File: rtl/vid_bridge_i2c_target.sv
module vid_bridge_i2c_target
  import vbt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h39,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  output logic ddcMode
);

  logic              sclS, sdaS, txMsb, reqFlag;
  logic [BYTE_W-1:0] rxByte, ptrVal;
  ctlStrobe_t        strb;

  vbt_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS)
  );

  vbt_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS)
  );

  vbt_bus_ctrl #(.TARGET_ADDR(TARGET_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .rxByte(rxByte), .txMsb(txMsb), .strb(strb), .sdaOe(sdaOe)
  );

  vbt_regfile u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .txMsb(txMsb),
    .ptrVal(ptrVal), .reqFlag(reqFlag), .ddcMode(ddcMode)
  );

endmodule

// File: rtl/vbt_checker.sv
module vbt_checker
  import vbt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sclS,
  input logic              sdaS,
  input logic              sdaOe,
  input logic              ddcMode,
  input logic              reqFlag,
  input logic [BYTE_W-1:0] ptrVal,
  input ctlStrobe_t        strb
);

  logic sclPrev, sdaPrev, stopSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign stopSeen = sclS & sclPrev & ~sdaPrev & sdaS;

  p_ddc_needs_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    ddcMode |-> reqFlag);

  p_ddc_rise_from_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ddcMode) |-> $past(strb.commitWrite));

  p_req_drop_clears_ddc_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqFlag) |-> !ddcMode);

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commitWrite || strb.loadTx) |=> $stable(ptrVal));

  p_ptr_step_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> (ptrVal == $past(ptrVal) + 8'd1));

  p_release_on_stop_r13: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

endmodule

bind vid_bridge_i2c_target vbt_checker u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .sdaOe(sdaOe),
  .ddcMode(ddcMode), .reqFlag(reqFlag), .ptrVal(ptrVal), .strb(strb)
);

// File: tb/vid_bridge_i2c_target_bench.sv
`timescale 1ns/1ps
module vid_bridge_i2c_target_bench;

  localparam int Q = 10;                // system clocks per quarter bit
  localparam logic [7:0] WR_ADDR = 8'h72;
  localparam logic [7:0] RD_ADDR = 8'h73;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe, ddcMode;
  wire  busSda = sdaDrv & ~sdaOe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [7:0] expVal[$];
  string      expReq[$];
  logic [7:0] obsVal[$];
  event       obsEv;

  always #2 clk = ~clk;

  vid_bridge_i2c_target u_vid_bridge_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(busSda),
    .sdaOe(sdaOe), .ddcMode(ddcMode)
  );

  // ---------------- scoreboard ----------------
  task automatic expectItem(input logic [7:0] v, input string r);
    expVal.push_back(v);
    expReq.push_back(r);
  endtask

  task automatic observe(input logic [7:0] v);
    obsVal.push_back(v);
    ->obsEv;
  endtask

  task automatic drain();
    while (obsVal.size() > 0) begin
      logic [7:0] o;
      o = obsVal.pop_front();
      compared++;
      if (expVal.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected item: actual=%02h expected=none", o);
      end else begin
        logic [7:0] e;
        string r;
        e = expVal.pop_front();
        r = expReq.pop_front();
        if (o !== e) begin
          mismatched++;
          $display("FAIL %s: actual=%02h expected=%02h", r, o, e);
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(obsEv);
      drain();
    end
  end

  // ---------------- bus driver ----------------
  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ();
      sclDrv = 1'b1; waitQ();
      sclDrv = 1'b0; waitQ();
    end
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    acked = ~busSda;
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic sendChecked(input logic [7:0] b, input logic expAck, input string r);
    logic a;
    sendByte(b, a);
    expectItem({7'd0, expAck}, r);
    observe({7'd0, a});
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclDrv = 1'b1; waitQ();
      v[i] = busSda;
      sclDrv = 1'b0; waitQ();
    end
    sdaDrv = ~giveAck; waitQ();
    sclDrv = 1'b1; waitQ();
    sclDrv = 1'b0; waitQ();
    sdaDrv = 1'b1;
  endtask

  function automatic logic [7:0] regModel(input logic [7:0] p, input logic req);
    case (p)
      8'h1A:   return req ? 8'h06 : 8'h00;
      8'h1B:   return 8'hB0;
      8'h3D:   return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  // Write pointer, then data bytes, then STOP
  task automatic writeSeq(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1,
                          input int n, input string r);
    i2cStart();
    sendChecked(WR_ADDR, 1'b1, "R1");
    sendChecked(p, 1'b1, "R2");
    if (n > 0) sendChecked(d0, 1'b1, r);
    if (n > 1) sendChecked(d1, 1'b1, r);
    i2cStop();
  endtask

  // Set pointer, repeated START read of n bytes, last NACKed, then STOP
  task automatic readSeq(input logic [7:0] p, input int n, input logic req, input string r);
    i2cStart();
    sendChecked(WR_ADDR, 1'b1, "R1");
    sendChecked(p, 1'b1, "R2");
    i2cStart();
    sendChecked(RD_ADDR, 1'b1, "R12");
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      readByte(i != n - 1, v);
      expectItem(regModel(p + 8'(i), req), r);
      observe(v);
    end
    waitQ();
    expectItem(8'h00, "R11");           // released after master NACK
    observe({7'd0, sdaOe});
    i2cStop();
  endtask

  task automatic checkDdc(input logic e, input string r);
    waitQ();
    expectItem({7'd0, e}, r);
    observe({7'd0, ddcMode});
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitQ();
    expectItem(8'h00, "R10"); observe({7'd0, sdaOe});
    expectItem(8'h00, "R10"); observe({7'd0, ddcMode});

    // R10: pointer starts at 0x00, a plain read returns location 0
    begin
      logic [7:0] v;
      i2cStart();
      sendChecked(RD_ADDR, 1'b1, "R10");
      readByte(1'b0, v);
      expectItem(8'h00, "R10"); observe(v);
      i2cStop();
    end

    readSeq(8'h1B, 3, 1'b0, "R4");      // 0xB0 then 0x00, 0x00 (R3, R9)
    readSeq(8'h3D, 1, 1'b0, "R5");
    readSeq(8'h1A, 1, 1'b0, "R8");      // request clear -> 0x00

    writeSeq(8'h1A, 8'h04, 8'h00, 1, "R6");
    checkDdc(1'b0, "R6");               // request only, no grant
    readSeq(8'h1A, 1, 1'b1, "R8");      // request set -> 0x06

    writeSeq(8'h19, 8'h00, 8'h06, 2, "R3");   // second byte lands on 0x1A
    checkDdc(1'b1, "R3");

    // R2: pointer byte 0x1A arriving while pointer is 0x1A must not write
    writeSeq(8'h19, 8'h55, 8'h00, 1, "R9");
    writeSeq(8'h1A, 8'h00, 8'h00, 0, "R2");
    checkDdc(1'b1, "R2");
    readSeq(8'h19, 1, 1'b1, "R9");

    // R1: foreign address, following bytes are ignored
    i2cStart();
    sendChecked(8'h40, 1'b0, "R1");
    sendChecked(8'h1A, 1'b0, "R1");
    sendChecked(8'h00, 1'b0, "R1");
    i2cStop();
    checkDdc(1'b1, "R1");

    // R7: bit 2 clear drops request and pass-through
    writeSeq(8'h1A, 8'h02, 8'h00, 1, "R7");
    checkDdc(1'b0, "R7");
    readSeq(8'h1A, 1, 1'b0, "R7");

    // R3: wrap from 0xFF through 0x00 to 0x1B
    readSeq(8'hFF, 29, 1'b0, "R3");

    // R13: STOP right after an address ACK leaves SDA free
    i2cStart();
    sendChecked(WR_ADDR, 1'b1, "R1");
    i2cStop();
    waitQ();
    expectItem(8'h00, "R13"); observe({7'd0, sdaOe});

    waitQ();
    drain();
    if (expVal.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", expVal.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R13 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule